// File: doc/BRIEF.md
# Per-core interrupt interface

This block is the front end that one processor core sees in a multiprocessor interrupt controller. It watches the core's 32 private interrupt lines and classifies each one by a 2-bit trigger code (high level, low level, rising edge, falling edge). It also takes shared interrupts (identifiers 32 and up) that a global distributor forwards to this core over a valid/ready stream. Among all pending, enabled interrupts that are not already in service, the lowest identifier is offered to the core. The core interrupt request output is high while such a candidate exists.

Software drives the block over a plain 32-bit register bus. A write has an effect in the cycle `bus_wr` is high. A read returns `bus_rdata` combinationally from `bus_addr` while `bus_rd` is high. Enable, disable and acknowledge each take an interrupt number rather than a bitmask. Reading the ready register claims the interrupt it returns and marks it active. An active interrupt is not offered again until software writes its number to the acknowledge register.

The forward stream follows the usual rules. A transfer happens in a cycle where `fwd_valid` and `fwd_ready` are both high. `fwd_ready` depends only on `fwd_id` and internal state. The distributor must hold `fwd_id` stable while `fwd_valid` is high and not yet accepted. Back-pressure is applied per identifier: a shared interrupt that is already pending or active is stalled until it has been acknowledged.

Top module: `cip_core`

## Requirements
- R1: After reset the control bit is 0, every interrupt is disabled and idle, all trigger codes are 0, `core_irq` is low, and the ready register at offset 0x6C reads 0xFFFFFFFF.
- R2: Bit 0 of the control register at offset 0x00 gates presentation. While it is 0, `core_irq` is low, the ready register reads 0xFFFFFFFF, and a ready read claims nothing.
- R3: Writing an interrupt number to offset 0xA0 enables that interrupt, and writing it to 0xA4 disables it. A written value of 64 or more is ignored.
- R4: Trigger codes for private interrupts 0..15 sit in the word at 0x14, and those for 16..31 in the word at 0x18. Interrupt i occupies bits [2*(i%16)+1 : 2*(i%16)]. Both words read back what was written.
- R5: Code 0 makes an interrupt pending while its line is high, and code 1 while its line is low. A level interrupt whose line is still asserted is offered again after it is acknowledged.
- R6: Code 2 latches a pending bit on a 0-to-1 line transition, and code 3 on a 1-to-0 transition. The bit stays set after the line returns to its old level, and it is cleared by writing the number to the acknowledge register at 0xB4.
- R7: When several interrupts are pending, enabled and not active, the lowest number is offered.
- R8: Reading 0x6C returns the offered number and marks it active. An active number is not offered again until it is acknowledged. With no candidate, `core_irq` is low and the read returns 0xFFFFFFFF.
- R9: A forwarded shared identifier (32..63) becomes pending when accepted. `fwd_ready` is low while that identifier is pending or active, and acknowledge clears both states. A forwarded identifier below 32 is accepted and has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 32 | Private interrupt lines, one per identifier 0..31 |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data |
| fwd_valid | input | 1 | Distributor offers a shared interrupt |
| fwd_ready | output | 1 | Block accepts the offered identifier |
| fwd_id | input | 6 | Offered interrupt identifier |
| core_irq | output | 1 | Interrupt request to the core |

## Verification
The hardest situations to reach from the ports are those in which interrupt state overlaps in time. One case is a claimed interrupt that must stay hidden while lower-priority candidates are still pending. Another is a level line that is still asserted at the moment of acknowledge. The stimulus builds these on purpose. It raises two lines, claims the lower one, and reads again so the next read has to skip the active entry. It also acknowledges a level interrupt while its line is held high. For the shared path, the same identifier is offered again while it is in service, to show the per-identifier stall, and the stall is then shown to lift on acknowledge.

// File: rtl/cip_pkg.sv
package cip_pkg;
  localparam int unsigned DW = 32;

  typedef enum logic [1:0] {
    TRG_LVL_HI = 2'd0,
    TRG_LVL_LO = 2'd1,
    TRG_RISE   = 2'd2,
    TRG_FALL   = 2'd3
  } trig_e;

  localparam logic [11:0] OFS_CTRL  = 12'h000;
  localparam logic [11:0] OFS_TRIG0 = 12'h014;
  localparam logic [11:0] OFS_READY = 12'h06C;
  localparam logic [11:0] OFS_SETEN = 12'h0A0;
  localparam logic [11:0] OFS_CLREN = 12'h0A4;
  localparam logic [11:0] OFS_ACK   = 12'h0B4;

  localparam logic [DW-1:0] ID_NONE = '1;
endpackage

// File: rtl/cip_line_det.sv
module cip_line_det
  import cip_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  line_in,
  input  trig_e mode,
  input  logic  ack_hit,
  output logic  pend
);
  logic samp, prev, edge_q, hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp <= 1'b0;
      prev <= 1'b0;
    end else begin
      samp <= line_in;
      prev <= samp;
    end
  end

  always_comb begin
    unique case (mode)
      TRG_RISE: hit = samp & ~prev;
      TRG_FALL: hit = ~samp & prev;
      default:  hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          edge_q <= 1'b0;
    else if (!mode[1])   edge_q <= 1'b0;
    else if (hit)        edge_q <= 1'b1;
    else if (ack_hit)    edge_q <= 1'b0;
  end

  assign pend = mode[1] ? edge_q : (samp ^ mode[0]);

  AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] && edge_q && !ack_hit) |=> edge_q); // R6
  AST_EDGE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(edge_q) |-> $past(hit)); // R6
endmodule

// File: rtl/cip_prio_enc.sv
module cip_prio_enc #(
  parameter int unsigned N  = 64,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/cip_core.sv
module cip_core
  import cip_pkg::*;
#(
  parameter int unsigned NUM_PRIV = 32,
  parameter int unsigned NUM_IDS  = 64,
  parameter int unsigned AW       = 12,
  parameter int unsigned IDW      = $clog2(NUM_IDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_PRIV-1:0] irq_lines,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic             fwd_valid,
  output logic             fwd_ready,
  input  logic [IDW-1:0]   fwd_id,
  output logic             core_irq
);
  localparam int unsigned NUM_SH     = NUM_IDS - NUM_PRIV;
  localparam int unsigned SHW        = $clog2(NUM_SH);
  localparam int unsigned PER_WORD   = DW / 2;
  localparam int unsigned TRIG_WORDS = (NUM_PRIV * 2 + DW - 1) / DW;

  logic                ctrl_en;
  logic [1:0]          trig [NUM_PRIV];
  logic [NUM_IDS-1:0]  en_q, act_q;
  logic [NUM_SH-1:0]   sh_pend;
  logic [NUM_PRIV-1:0] priv_pend;
  logic [NUM_IDS-1:0]  cand;
  logic                found, pres, claim;
  logic [IDW-1:0]      sel_id;

  // Number written to a by-number register.
  logic           id_ok;
  logic [IDW-1:0] wr_id;
  assign id_ok = (bus_wdata < DW'(NUM_IDS));
  assign wr_id = bus_wdata[IDW-1:0];

  logic wr_ctrl, wr_seten, wr_clren, ack_do;
  assign wr_ctrl  = bus_wr && (bus_addr == AW'(OFS_CTRL));
  assign wr_seten = bus_wr && (bus_addr == AW'(OFS_SETEN)) && id_ok;
  assign wr_clren = bus_wr && (bus_addr == AW'(OFS_CLREN)) && id_ok;
  assign ack_do   = bus_wr && (bus_addr == AW'(OFS_ACK)) && id_ok;

  // Shared forward stream.
  logic           fwd_shared, fwd_take;
  logic [SHW-1:0] fwd_sh;
  assign fwd_shared = (fwd_id >= IDW'(NUM_PRIV));
  assign fwd_sh     = SHW'(fwd_id - IDW'(NUM_PRIV));
  assign fwd_ready  = !fwd_shared || !(sh_pend[fwd_sh] || act_q[fwd_id]);
  assign fwd_take   = fwd_valid && fwd_ready && fwd_shared;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_en <= 1'b0;
    else if (wr_ctrl) ctrl_en <= bus_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PRIV; i++) trig[i] <= 2'd0;
    end else if (bus_wr) begin
      for (int w = 0; w < TRIG_WORDS; w++) begin
        if (bus_addr == AW'(OFS_TRIG0) + AW'(4 * w)) begin
          for (int j = 0; j < PER_WORD; j++) begin
            if (w * PER_WORD + j < NUM_PRIV)
              trig[w * PER_WORD + j] <= bus_wdata[2*j +: 2];
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else begin
      if (wr_seten) en_q[wr_id] <= 1'b1;
      if (wr_clren) en_q[wr_id] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
    end else begin
      if (claim)  act_q[sel_id] <= 1'b1;
      if (ack_do) act_q[wr_id]  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_pend <= '0;
    end else begin
      if (ack_do && wr_id >= IDW'(NUM_PRIV))
        sh_pend[SHW'(wr_id - IDW'(NUM_PRIV))] <= 1'b0;
      if (fwd_take)
        sh_pend[fwd_sh] <= 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_PRIV; g++) begin : g_line
    cip_line_det u_det (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_in (irq_lines[g]),
      .mode    (trig_e'(trig[g])),
      .ack_hit (ack_do && (wr_id == IDW'(g))),
      .pend    (priv_pend[g])
    );
  end

  assign cand = {sh_pend, priv_pend} & en_q & ~act_q;

  cip_prio_enc #(.N(NUM_IDS), .IW(IDW)) u_prio (
    .req   (cand),
    .found (found),
    .idx   (sel_id)
  );

  assign pres     = found && ctrl_en;
  assign core_irq = pres;
  assign claim    = bus_rd && (bus_addr == AW'(OFS_READY)) && pres;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(OFS_CTRL)) bus_rdata = {{(DW-1){1'b0}}, ctrl_en};
    if (bus_addr == AW'(OFS_READY)) bus_rdata = pres ? DW'(sel_id) : ID_NONE;
    for (int w = 0; w < TRIG_WORDS; w++) begin
      if (bus_addr == AW'(OFS_TRIG0) + AW'(4 * w)) begin
        for (int j = 0; j < PER_WORD; j++) begin
          if (w * PER_WORD + j < NUM_PRIV)
            bus_rdata[2*j +: 2] = trig[w * PER_WORD + j];
        end
      end
    end
  end

  AST_CLAIM_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
    (claim && !(ack_do && wr_id == sel_id)) |=> act_q[$past(sel_id)]); // R8
  AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_do && !claim) |=> !act_q[$past(wr_id)]); // R8
  AST_FWD_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_take |=> sh_pend[$past(fwd_sh)]); // R9
  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (cand[sel_id] && ((cand & ((NUM_IDS'(1) << sel_id) - NUM_IDS'(1))) == '0))); // R7
  AST_IDLE_READS_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_irq && bus_addr == AW'(OFS_READY)) |-> (bus_rdata == ID_NONE)); // R8
  AST_OFF_NO_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_en) |=> ($past(act_q) == act_q) || $past(ack_do)); // R2
endmodule

// File: tb/sim_cip_core.sv
module sim_cip_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_lines = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        fwd_valid = 1'b0;
  logic        fwd_ready;
  logic [5:0]  fwd_id = '0;
  logic        core_irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct { logic [31:0] v; string tag; } exp_t;
  exp_t        exp_q[$];
  logic [31:0] obs_q[$];

  always #2.5 clk = ~clk;

  cip_core u0 (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_id(fwd_id),
    .core_irq(core_irq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected and observed read values and compares them.
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0 && obs_q.size() > 0) begin
        exp_t e;
        logic [31:0] o;
        e = exp_q.pop_front();
        o = obs_q.pop_front();
        chk(o, e.v, e.tag);
      end
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // Driver: push the expected value, then perform the read.
  task automatic rd_exp(input logic [11:0] a, input logic [31:0] e, input string tag);
    exp_t x;
    x.v = e; x.tag = tag;
    exp_q.push_back(x);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1;
    obs_q.push_back(bus_rdata);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic fwd(input logic [5:0] id, input logic exp_rdy, input string tag);
    @(negedge clk);
    fwd_valid = 1'b1; fwd_id = id;
    #1;
    chk({31'b0, fwd_ready}, {31'b0, exp_rdy}, tag);
    @(negedge clk);
    fwd_valid = 1'b0;
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    chk({31'b0, core_irq}, 32'd0, "R1 irq after reset");
    rd_exp(12'h06C, 32'hFFFF_FFFF, "R1 ready after reset");
    rd_exp(12'h000, 32'd0, "R1 ctrl after reset");
    rd_exp(12'h014, 32'd0, "R1 trig word after reset");

    // R5 level high, re-offer after ack
    wr(12'h000, 32'd1);
    wr(12'h0A0, 32'd3);
    irq_lines[3] = 1'b1;
    wait_cyc(2);
    chk({31'b0, core_irq}, 32'd1, "R5 level high pending");
    rd_exp(12'h06C, 32'd3, "R5 ready id 3");
    wait_cyc(1);
    chk({31'b0, core_irq}, 32'd0, "R8 active not offered");
    wr(12'h0B4, 32'd3);
    wait_cyc(1);
    chk({31'b0, core_irq}, 32'd1, "R5 level re-offered after ack");
    rd_exp(12'h06C, 32'd3, "R5 reclaim id 3");
    irq_lines[3] = 1'b0;
    wr(12'h0B4, 32'd3);
    wait_cyc(2);
    chk({31'b0, core_irq}, 32'd0, "R8 idle irq low");
    rd_exp(12'h06C, 32'hFFFF_FFFF, "R8 idle reads none");

    // R7 priority
    wr(12'h0A0, 32'd5);
    wr(12'h0A0, 32'd9);
    irq_lines[9] = 1'b1;
    wait_cyc(1);
    irq_lines[5] = 1'b1;
    wait_cyc(2);
    rd_exp(12'h06C, 32'd5, "R7 lowest first");
    rd_exp(12'h06C, 32'd9, "R7 next skips active");
    rd_exp(12'h06C, 32'hFFFF_FFFF, "R8 all active reads none");
    irq_lines[5] = 1'b0; irq_lines[9] = 1'b0;
    wr(12'h0B4, 32'd5);
    wr(12'h0B4, 32'd9);

    // R3 enable by number, out of range ignored
    wr(12'h0A0, 32'd71);
    irq_lines[7] = 1'b1;
    wait_cyc(2);
    chk({31'b0, core_irq}, 32'd0, "R3 out-of-range enable ignored");
    wr(12'h0A0, 32'd7);
    wait_cyc(1);
    chk({31'b0, core_irq}, 32'd1, "R3 enable by number");
    wr(12'h0A4, 32'd7);
    wait_cyc(1);
    chk({31'b0, core_irq}, 32'd0, "R3 disable by number");
    irq_lines[7] = 1'b0;

    // R4 / R6 rising edge on id 2
    wr(12'h014, 32'h0000_0020);
    rd_exp(12'h014, 32'h0000_0020, "R4 trig word 0 readback");
    wr(12'h0A0, 32'd2);
    irq_lines[2] = 1'b1;
    wait_cyc(1);
    irq_lines[2] = 1'b0;
    wait_cyc(4);
    chk({31'b0, core_irq}, 32'd1, "R6 rising edge latched");
    rd_exp(12'h06C, 32'd2, "R6 ready id 2");
    wr(12'h0B4, 32'd2);
    wait_cyc(1);
    chk({31'b0, core_irq}, 32'd0, "R6 ack clears edge");

    // R4 / R6 falling edge on id 20, R5 active-low on id 17
    wr(12'h018, 32'h0000_0300);
    rd_exp(12'h018, 32'h0000_0300, "R4 trig word 1 readback");
    irq_lines[20] = 1'b1;
    wait_cyc(3);
    wr(12'h0A0, 32'd20);
    wait_cyc(1);
    chk({31'b0, core_irq}, 32'd0, "R6 high level no falling event");
    irq_lines[20] = 1'b0;
    wait_cyc(4);
    chk({31'b0, core_irq}, 32'd1, "R6 falling edge latched");
    rd_exp(12'h06C, 32'd20, "R6 ready id 20");
    wr(12'h0B4, 32'd20);
    wr(12'h018, 32'h0000_0304);
    wr(12'h0A0, 32'd17);
    wait_cyc(1);
    chk({31'b0, core_irq}, 32'd1, "R5 active-low pending with line low");
    rd_exp(12'h06C, 32'd17, "R5 ready id 17");
    irq_lines[17] = 1'b1;
    wr(12'h0B4, 32'd17);
    wait_cyc(2);
    chk({31'b0, core_irq}, 32'd0, "R5 active-low released");

    // R2 control gate
    irq_lines[3] = 1'b1;
    wait_cyc(2);
    wr(12'h000, 32'd0);
    wait_cyc(1);
    chk({31'b0, core_irq}, 32'd0, "R2 disabled irq low");
    rd_exp(12'h06C, 32'hFFFF_FFFF, "R2 disabled reads none");
    wr(12'h000, 32'd1);
    wait_cyc(1);
    chk({31'b0, core_irq}, 32'd1, "R2 re-enabled, not claimed while off");
    rd_exp(12'h06C, 32'd3, "R2 ready id 3");
    irq_lines[3] = 1'b0;
    wr(12'h0B4, 32'd3);
    wait_cyc(2);

    // R9 shared forward stream
    wr(12'h0A0, 32'd40);
    fwd(6'd40, 1'b1, "R9 ready for idle shared id");
    wait_cyc(1);
    chk({31'b0, core_irq}, 32'd1, "R9 shared pending");
    rd_exp(12'h06C, 32'd40, "R9 ready id 40");
    fwd(6'd40, 1'b0, "R9 stall while active");
    wr(12'h0B4, 32'd40);
    wait_cyc(1);
    chk({31'b0, core_irq}, 32'd0, "R9 ack clears shared pending");
    fwd(6'd41, 1'b1, "R9 other id accepted");
    wr(12'h0A0, 32'd10);
    fwd(6'd10, 1'b1, "R9 private id accepted");
    wait_cyc(2);
    chk({31'b0, core_irq}, 32'd0, "R9 private forward no effect");
    wait_cyc(4);
    if (exp_q.size() != 0 || obs_q.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", exp_q.size() + obs_q.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule